// File: doc/BRIEF.md
# Banked Data Memory with Access Window

This block is the byte-wide data store of a small microcontroller core. An instruction supplies an 8-bit operand and a one-bit bank-use flag. A 4-bit bank register, loaded through its own port, supplies the upper address bits. Together they form a 12-bit effective address that spans sixteen banks of 256 bytes each.

When the bank-use flag is set, the bank register and the operand are joined to form the address. When the flag is clear, the bank register has no effect and the operand selects a byte of a 256-byte access window. The low part of that window is the start of bank 0 RAM. The high part is the special function register region at the top of bank 15.

Only banks 0 to 2 and the upper 160 bytes of bank 15 hold storage. Every other location reads as zero and ignores writes. Writes are synchronous. The read port is registered by default, and a parameter selects a combinational read instead.

Top module: `banked_dmem`

## Requirements
- R1: When use_bank is 1, the effective address is bsr_q in bits 11:8 and operand in bits 7:0. A byte written this way reads back through the same bank and offset.
- R2: When use_bank is 0 and operand is below 60h, the effective address is 000h plus operand, whatever value bsr_q holds.
- R3: When use_bank is 0 and operand is 60h or above, the effective address is F00h plus operand, which covers F60h to FFFh. The same bytes are reached with bank 15 and use_bank set to 1.
- R4: Addresses 000h to 2FFh (banks 0, 1 and 2) store bytes independently, with no aliasing between banks.
- R5: A read of any address from 300h to EFFh, or from F00h to F5Fh, returns 00h.
- R6: A write to an unimplemented address changes no stored byte. This includes the bytes at the same offset in banks 0 to 2.
- R7: bsr_q is 0 after reset. When bsr_we is high, bsr_q takes bsr_wdata bits 3:0 at the next edge, and bits 7:4 are dropped. An access in the same cycle as a load uses the old bsr_q.
- R8: With the default registered read, rd_data shows the addressed byte one edge after the address is presented. If a write to the same address happens in that cycle, rd_data shows the byte as it was before the write.
- R9: Reset clears every stored byte and rd_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bsr_we | input | 1 | Load strobe for the bank register |
| bsr_wdata | input | 8 | Load value; only bits 3:0 are kept |
| bsr_q | output | 4 | Current bank register value |
| use_bank | input | 1 | 1: address through bank register; 0: access window |
| operand | input | 8 | Address offset from the instruction |
| wr_en | input | 1 | Byte write enable |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Read byte (registered by default) |

## Verification
Every access presented at a falling edge is due on rd_data one rising edge later. A bank register load is due on bsr_q at that same rising edge. The driver queues the expected byte in the cycle it drives the access, and the monitor removes exactly one item 5 ns after each rising edge. The expected value is taken from the bench's own memory model before the write is applied to that model. This makes the read-before-write case fall out of the ordering naturally.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef enum logic [1:0] {
        RG_GPR  = 2'd0,
        RG_SFR  = 2'd1,
        RG_NONE = 2'd2
    } region_e;
endpackage

// File: rtl/dmem_bsr.sv
module dmem_bsr #(
    parameter int BANK_W = 4,
    parameter int LOAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LOAD_W-1:0] wdata,
    output logic [BANK_W-1:0] bsr_q
);
    logic [BANK_W-1:0] bsr_d;
    logic              unused_hi;

    assign unused_hi = ^wdata[LOAD_W-1:BANK_W];

    always_comb begin
        bsr_d = bsr_q;
        if (we) bsr_d = wdata[BANK_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bsr_q <= '0;
        else        bsr_q <= bsr_d;
    end

    // R7: a load shows on bsr_q at the following edge
    assert_bsr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> bsr_q == $past(wdata[BANK_W-1:0]));
endmodule

// File: rtl/dmem_addr_map.sv
module dmem_addr_map
    import dmem_pkg::*;
#(
    parameter int OFF_W     = 8,
    parameter int BANK_W    = 4,
    parameter int GPR_BANKS = 3,
    parameter int SPLIT     = 96,
    parameter int IDX_W     = 10,
    localparam int AW       = OFF_W + BANK_W
) (
    input  logic [BANK_W-1:0] bsr,
    input  logic [OFF_W-1:0]  operand,
    input  logic              use_bank,
    output logic [AW-1:0]     eff_addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam int BANK_SZ  = 1 << OFF_W;
    localparam int GPR_SIZE = GPR_BANKS * BANK_SZ;
    localparam logic [BANK_W-1:0] TOP_BANK = '1;

    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  off;

    always_comb begin
        if (use_bank)                      eff_addr = {bsr, operand};
        else if (operand < OFF_W'(SPLIT))  eff_addr = {{BANK_W{1'b0}}, operand};
        else                               eff_addr = {TOP_BANK, operand};

        bank   = eff_addr[AW-1:OFF_W];
        off    = eff_addr[OFF_W-1:0];
        region = RG_NONE;
        idx    = '0;
        if (bank < BANK_W'(GPR_BANKS)) begin
            region = RG_GPR;
            idx    = IDX_W'(eff_addr);
        end else if (bank == TOP_BANK && off >= OFF_W'(SPLIT)) begin
            region = RG_SFR;
            idx    = IDX_W'(GPR_SIZE + int'(off) - SPLIT);
        end
    end
endmodule

// File: rtl/dmem_store.sv
module dmem_store #(
    parameter int DW       = 8,
    parameter int DEPTH    = 928,
    parameter int IDX_W    = 10,
    parameter bit READ_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_d;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_en && hit) mem_d[idx] = wr_data;
        rd_d = hit ? mem_q[idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    generate
        if (READ_REG) begin : g_rd_reg
            logic [DW-1:0] rd_q;
            always_ff @(posedge clk) begin
                if (!rst_n) rd_q <= '0;
                else        rd_q <= rd_d;
            end
            assign rd_data = rd_q;

            // R5: a miss in the map yields zero on the next read
            assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !hit |=> rd_data == '0);
        end else begin : g_rd_comb
            assign rd_data = rd_d;

            // R5: combinational variant
            assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !hit |-> rd_data == '0);
        end
    endgenerate
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
    import dmem_pkg::*;
#(
    parameter int DW        = 8,
    parameter int OFF_W     = 8,
    parameter int BANK_W    = 4,
    parameter int GPR_BANKS = 3,
    parameter int SPLIT     = 96,
    parameter bit READ_REG  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bsr_we,
    input  logic [7:0]        bsr_wdata,
    output logic [BANK_W-1:0] bsr_q,
    input  logic              use_bank,
    input  logic [OFF_W-1:0]  operand,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data
);
    localparam int AW      = OFF_W + BANK_W;
    localparam int BANK_SZ = 1 << OFF_W;
    localparam int DEPTH   = GPR_BANKS * BANK_SZ + (BANK_SZ - SPLIT);
    localparam int IDX_W   = $clog2(DEPTH);
    localparam logic [BANK_W-1:0] TOP_BANK = '1;

    logic [AW-1:0]    eff_addr;
    region_e          region;
    logic [IDX_W-1:0] idx;
    logic             hit;

    dmem_bsr #(.BANK_W(BANK_W), .LOAD_W(8)) u_bsr (
        .clk(clk), .rst_n(rst_n), .we(bsr_we), .wdata(bsr_wdata), .bsr_q(bsr_q)
    );

    dmem_addr_map #(
        .OFF_W(OFF_W), .BANK_W(BANK_W), .GPR_BANKS(GPR_BANKS),
        .SPLIT(SPLIT), .IDX_W(IDX_W)
    ) u_map (
        .bsr(bsr_q), .operand(operand), .use_bank(use_bank),
        .eff_addr(eff_addr), .region(region), .idx(idx)
    );

    assign hit = (region != RG_NONE);

    dmem_store #(
        .DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W), .READ_REG(READ_REG)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .hit(hit), .idx(idx),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    // R2: low window offsets land in bank 0 as general RAM
    assert_win_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_bank && operand < OFF_W'(SPLIT)) |->
            (eff_addr[AW-1:OFF_W] == '0 && region == RG_GPR));

    // R3: high window offsets land in the top-bank register region
    assert_win_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_bank && operand >= OFF_W'(SPLIT)) |->
            (eff_addr[AW-1:OFF_W] == TOP_BANK && region == RG_SFR));
endmodule

// File: tb/sim_banked_dmem.sv
module sim_banked_dmem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bsr_we = 1'b0;
    logic [7:0] bsr_wdata = '0;
    logic [3:0] bsr_q;
    logic       use_bank = 1'b0;
    logic [7:0] operand = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] model [4096];
    logic [3:0] tb_bsr = '0;

    int exp_q [$];
    int req_q [$];
    int kind_q [$];

    always #10 clk = ~clk;

    banked_dmem u0 (
        .clk(clk), .rst_n(rst_n), .bsr_we(bsr_we), .bsr_wdata(bsr_wdata),
        .bsr_q(bsr_q), .use_bank(use_bank), .operand(operand),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [11:0] eff(input logic ub, input logic [3:0] b, input logic [7:0] op);
        if (ub)           return {b, op};
        else if (op < 8'h60) return {4'h0, op};
        else              return {4'hF, op};
    endfunction

    function automatic bit implemented(input logic [11:0] a);
        return (a < 12'h300) || (a >= 12'hF60);
    endfunction

    task automatic check(input int req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic acc(input logic ub, input logic [7:0] op, input logic we,
                       input logic [7:0] wd, input int req);
        logic [11:0] a;
        @(negedge clk);
        bsr_we   = 1'b0;
        use_bank = ub;
        operand  = op;
        wr_en    = we;
        wr_data  = wd;
        a = eff(ub, tb_bsr, op);
        exp_q.push_back(implemented(a) ? int'(model[a]) : 0);
        req_q.push_back(req);
        kind_q.push_back(0);
        if (we && implemented(a)) model[a] = wd;
    endtask

    task automatic ldbsr(input logic [7:0] v);
        @(negedge clk);
        bsr_we    = 1'b1;
        bsr_wdata = v;
        wr_en     = 1'b0;
        exp_q.push_back(int'(v[3:0]));
        req_q.push_back(7);
        kind_q.push_back(1);
        tb_bsr = v[3:0];
    endtask

    always @(posedge clk) begin
        #5;
        if (kind_q.size() > 0) begin
            int k, e, r;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (k == 1) check(r, int'(bsr_q), e);
            else        check(r, int'(rd_data), e);
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7 and R9: reset state
        check(7, int'(bsr_q), 0);
        check(9, int'(rd_data), 0);
        acc(1'b1, 8'h10, 1'b0, 8'h00, 9);
        acc(1'b0, 8'hFF, 1'b0, 8'h00, 9);

        // R7: only the low nibble is kept
        ldbsr(8'hA1);
        // R1 and R4: banked write and read in bank 1
        acc(1'b1, 8'h10, 1'b1, 8'h33, 1);
        acc(1'b1, 8'h10, 1'b0, 8'h00, 1);
        ldbsr(8'h00);
        acc(1'b1, 8'h10, 1'b1, 8'h11, 4);
        ldbsr(8'h02);
        acc(1'b1, 8'h10, 1'b1, 8'h22, 4);
        acc(1'b1, 8'hFF, 1'b1, 8'hC3, 4);
        acc(1'b1, 8'hFF, 1'b0, 8'h00, 4);
        // R2: access window low part ignores the bank register (bank 2 loaded)
        acc(1'b0, 8'h10, 1'b0, 8'h00, 2);
        acc(1'b0, 8'h5F, 1'b1, 8'h5E, 2);
        ldbsr(8'h00);
        acc(1'b1, 8'h5F, 1'b0, 8'h00, 2);
        // R3: access window high part equals bank 15
        acc(1'b0, 8'h60, 1'b1, 8'h60, 3);
        acc(1'b0, 8'hFF, 1'b1, 8'hA5, 3);
        acc(1'b0, 8'h80, 1'b1, 8'h77, 3);
        ldbsr(8'h0F);
        acc(1'b1, 8'h60, 1'b0, 8'h00, 3);
        acc(1'b1, 8'hFF, 1'b0, 8'h00, 3);
        acc(1'b1, 8'h80, 1'b0, 8'h00, 3);
        // R5 and R6: unused part of bank 15
        acc(1'b1, 8'h20, 1'b1, 8'h99, 6);
        acc(1'b1, 8'h20, 1'b0, 8'h00, 5);
        acc(1'b1, 8'h5F, 1'b0, 8'h00, 5);
        // R5 and R6: banks 3 and 14
        ldbsr(8'h03);
        acc(1'b1, 8'h10, 1'b1, 8'hEE, 6);
        acc(1'b1, 8'h10, 1'b0, 8'h00, 5);
        acc(1'b1, 8'h00, 1'b0, 8'h00, 5);
        ldbsr(8'h0E);
        acc(1'b1, 8'hFF, 1'b1, 8'h44, 6);
        acc(1'b1, 8'hFF, 1'b0, 8'h00, 5);
        // R6: no aliasing into banks 0 to 2
        acc(1'b0, 8'h10, 1'b0, 8'h00, 6);
        ldbsr(8'h01);
        acc(1'b1, 8'h10, 1'b0, 8'h00, 6);
        ldbsr(8'h02);
        acc(1'b1, 8'h10, 1'b0, 8'h00, 6);
        acc(1'b1, 8'hFF, 1'b0, 8'h00, 6);
        // R8: read-before-write on the same address, then the new value
        acc(1'b1, 8'h10, 1'b1, 8'h5A, 8);
        acc(1'b1, 8'h10, 1'b1, 8'h6B, 8);
        acc(1'b1, 8'h10, 1'b0, 8'h00, 8);
        // R7: a load in the same cycle as an access uses the old bank
        @(negedge clk);
        bsr_we = 1'b1; bsr_wdata = 8'hF0;
        use_bank = 1'b1; operand = 8'h10; wr_en = 1'b0;
        exp_q.push_back(int'(model[12'h210])); req_q.push_back(7); kind_q.push_back(0);
        tb_bsr = 4'h0;
        acc(1'b1, 8'h10, 1'b0, 8'h00, 7);
        @(negedge clk);
        bsr_we = 1'b0; wr_en = 1'b0;
        check(7, int'(bsr_q), 0);

        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule